// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides, each cycle, which hardware thread the retire stage of a multithreaded core draws instructions from. For every thread it receives an active flag, a lifecycle state, a per-slot ready mask and non-speculative mask for the oldest `COMMIT_W` reorder-buffer slots, and the sequence number of the oldest instruction. A two-bit policy input chooses how to arbitrate among the eligible threads. The selection is combinational and is presented as a valid/ready offer to the retire stage.

The offer (`sel_valid`, `sel_tid`, `sel_count`, `sel_nonspec`) is valid whenever at least one thread is eligible. `sel_valid` never waits on `sel_ready`. The retire stage takes the offer by raising `sel_ready` while `sel_valid` is high. While `sel_ready` is low the offer may change with the inputs, and no arbiter state moves. The only state is the rotating priority order. It advances only on an accepted offer made under the rotating policy.

Top module: `cts_commit_select`

## Requirements
- R1: A thread is eligible only when its active flag is 1, its state code is 0 (running; the codes are 1 idle, 2 squashing, 3 trap pending, 4 fetch-trap pending) and bit 0 of its ready slice is 1. `sel_valid` is 1 exactly when some thread is eligible, and `sel_tid` always names an eligible thread.
- R2: Under policy 0 (greedy), and also under the unused code 3, the lowest-index eligible thread is offered.
- R3: Under policy 1 (rotating), the offered thread is the eligible thread that appears first in a priority order. Reset sets that order to 0, 1, ..., N-1.
- R4: When an offer is accepted under policy 1, the granted thread moves to the tail of the order. The other threads keep their relative order.
- R5: The order does not change in a cycle where `sel_ready` is low, where `sel_valid` is low, or where the policy is not 1.
- R6: Under policy 2 (oldest), the eligible thread with the smallest unsigned head sequence number is offered. A tie goes to the lower thread index.
- R7: `sel_count` equals the number of consecutive slots, counted from slot 0, that are ready and not non-speculative. It is at most `COMMIT_W`. Slot i of thread t is bit t*COMMIT_W+i of the mask inputs.
- R8: When slot 0 of the offered thread is non-speculative, `sel_count` is 1 and `sel_nonspec` is 1. Otherwise `sel_nonspec` is 0, and a non-speculative slot deeper in the window ends the count before that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | 0 greedy, 1 rotating, 2 oldest, 3 greedy |
| thr_active | input | NUM_THREADS | Per-thread active flag |
| thr_state | input | 3*NUM_THREADS | Per-thread state code, thread t at bits 3t+2:3t |
| head_ready | input | NUM_THREADS*COMMIT_W | Per-slot completed flags |
| head_nonspec | input | NUM_THREADS*COMMIT_W | Per-slot non-speculative flags |
| head_seq | input | NUM_THREADS*SEQ_W | Oldest-instruction sequence number per thread |
| sel_valid | output | 1 | An offer is present |
| sel_ready | input | 1 | Retire stage accepts the offer |
| sel_tid | output | TID_W | Offered thread |
| sel_count | output | CNT_W | Instructions to retire from it |
| sel_nonspec | output | 1 | The single instruction offered is non-speculative |

## Verification
Two of the block's functions can meet in one cycle: an accepted offer that rotates the priority order, and back-pressure or a policy other than rotating that must freeze the order. The bench exercises this in two ways. It holds `sel_ready` low across a clock edge under the rotating policy. It also accepts offers while the oldest policy is selected, then switches back to rotating. In both cases the offer seen afterwards must match the order that existed before those cycles. A second coincidence is a thread dropping out of eligibility while it is next in the order. The bench judges this by whether the following thread in the order is offered instead.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,
    TS_IDLE   = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_SPARE  = 2'd3
  } pol_e;
endpackage

// File: rtl/cts_thread_qual.sv
module cts_thread_qual #(
  parameter int COMMIT_W = 4,
  localparam int CNT_W = $clog2(COMMIT_W + 1)
) (
  input  logic                active,
  input  logic [2:0]          state,
  input  logic [COMMIT_W-1:0] ready,
  input  logic [COMMIT_W-1:0] nonspec,
  output logic                elig,
  output logic [CNT_W-1:0]    count,
  output logic                ns_head
);
  import cts_pkg::*;

  always_comb begin
    logic run;
    count = '0;
    run   = 1'b1;
    if (nonspec[0]) begin
      count = CNT_W'(1);
    end else begin
      for (int i = 0; i < COMMIT_W; i++) begin
        if (run && ready[i] && !nonspec[i]) count = count + CNT_W'(1);
        else run = 1'b0;
      end
    end
  end

  assign elig    = active && (state == TS_RUN) && ready[0];
  assign ns_head = nonspec[0];
endmodule

// File: rtl/cts_rotate_arb.sv
module cts_rotate_arb #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] elig,
  input  logic                   advance,
  output logic                   found,
  output logic [TID_W-1:0]       tid
);
  logic [TID_W-1:0] order_q [NUM_THREADS];
  int               pos;

  always_comb begin
    found = 1'b0;
    tid   = '0;
    pos   = 0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!found && elig[order_q[p]]) begin
        found = 1'b1;
        tid   = order_q[p];
        pos   = p;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= TID_W'(p);
    end else if (advance && found) begin
      for (int p = 0; p < NUM_THREADS - 1; p++) begin
        if (p >= pos) order_q[p] <= order_q[p+1];
      end
      order_q[NUM_THREADS-1] <= tid;
    end
  end
endmodule

// File: rtl/cts_oldest_pick.sv
module cts_oldest_pick #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]       elig,
  input  logic [NUM_THREADS*SEQ_W-1:0] seq,
  output logic [TID_W-1:0]             tid
);
  always_comb begin
    logic             have;
    logic [SEQ_W-1:0] best;
    have = 1'b0;
    best = '0;
    tid  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig[t] && (!have || seq[t*SEQ_W +: SEQ_W] < best)) begin
        have = 1'b1;
        best = seq[t*SEQ_W +: SEQ_W];
        tid  = TID_W'(t);
      end
    end
  end
endmodule

// File: rtl/cts_commit_select.sv
module cts_commit_select #(
  parameter int NUM_THREADS = 4,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W = $clog2(COMMIT_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    policy,
  input  logic [NUM_THREADS-1:0]        thr_active,
  input  logic [3*NUM_THREADS-1:0]      thr_state,
  input  logic [NUM_THREADS*COMMIT_W-1:0] head_ready,
  input  logic [NUM_THREADS*COMMIT_W-1:0] head_nonspec,
  input  logic [NUM_THREADS*SEQ_W-1:0]  head_seq,
  output logic                          sel_valid,
  input  logic                          sel_ready,
  output logic [TID_W-1:0]              sel_tid,
  output logic [CNT_W-1:0]              sel_count,
  output logic                          sel_nonspec
);
  import cts_pkg::*;

  logic [NUM_THREADS-1:0] elig;
  logic [NUM_THREADS-1:0] ns_head;
  logic [CNT_W-1:0]       cnt [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_qual
    cts_thread_qual #(.COMMIT_W(COMMIT_W)) u_qual (
      .active  (thr_active[t]),
      .state   (thr_state[3*t +: 3]),
      .ready   (head_ready[t*COMMIT_W +: COMMIT_W]),
      .nonspec (head_nonspec[t*COMMIT_W +: COMMIT_W]),
      .elig    (elig[t]),
      .count   (cnt[t]),
      .ns_head (ns_head[t])
    );
  end

  logic [TID_W-1:0] greedy_tid;
  always_comb begin
    greedy_tid = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--) begin
      if (elig[t]) greedy_tid = TID_W'(t);
    end
  end

  logic             rot_found;
  logic [TID_W-1:0] rot_tid;
  logic             rot_adv;
  assign rot_adv = (pol_e'(policy) == POL_ROTATE) && sel_valid && sel_ready;

  cts_rotate_arb #(.NUM_THREADS(NUM_THREADS)) u_rot (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .advance (rot_adv),
    .found   (rot_found),
    .tid     (rot_tid)
  );

  logic [TID_W-1:0] old_tid;
  cts_oldest_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)) u_old (
    .elig (elig),
    .seq  (head_seq),
    .tid  (old_tid)
  );

  always_comb begin
    case (pol_e'(policy))
      POL_ROTATE: sel_tid = rot_tid;
      POL_OLDEST: sel_tid = old_tid;
      default:    sel_tid = greedy_tid;
    endcase
  end

  assign sel_valid   = |elig;
  assign sel_count   = sel_valid ? cnt[sel_tid] : '0;
  assign sel_nonspec = sel_valid && ns_head[sel_tid];
endmodule

// File: rtl/cts_commit_select_chk.sv
module cts_commit_select_chk #(
  parameter int NUM_THREADS = 4,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W = $clog2(COMMIT_W + 1)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [1:0]                      policy,
  input logic [NUM_THREADS-1:0]          thr_active,
  input logic [3*NUM_THREADS-1:0]        thr_state,
  input logic [NUM_THREADS*COMMIT_W-1:0] head_ready,
  input logic [NUM_THREADS*COMMIT_W-1:0] head_nonspec,
  input logic [NUM_THREADS*SEQ_W-1:0]    head_seq,
  input logic                            sel_valid,
  input logic                            sel_ready,
  input logic [TID_W-1:0]                sel_tid,
  input logic [CNT_W-1:0]                sel_count,
  input logic                            sel_nonspec
);
  logic [NUM_THREADS-1:0] ok;
  logic greedy_ok, oldest_ok, tid_ok, ns_slot0;

  always_comb begin
    greedy_ok = 1'b1;
    oldest_ok = 1'b1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      ok[t] = thr_active[t] && (thr_state[3*t +: 3] == 3'd0) && head_ready[t*COMMIT_W];
    end
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (ok[t] && t < int'(sel_tid)) greedy_ok = 1'b0;
      if (ok[t] && head_seq[t*SEQ_W +: SEQ_W] < head_seq[int'(sel_tid)*SEQ_W +: SEQ_W])
        oldest_ok = 1'b0;
    end
    tid_ok   = ok[sel_tid];
    ns_slot0 = head_nonspec[int'(sel_tid)*COMMIT_W];
  end

  assert_elig_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> tid_ok);
  assert_valid_iff_any_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == (ok != '0));
  assert_lowest_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && policy != 2'd1 && policy != 2'd2) |-> greedy_ok);
  assert_moves_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_ready && policy == 2'd1) |=>
      ((policy == 2'd1 && sel_valid && $countones(ok) >= 2) |-> sel_tid != $past(sel_tid)));
  assert_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && policy == 2'd2) |-> oldest_ok);
  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_count >= CNT_W'(1) && sel_count <= CNT_W'(COMMIT_W)));
  assert_single_nonspec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && ns_slot0) |-> (sel_count == CNT_W'(1) && sel_nonspec));
endmodule

bind cts_commit_select cts_commit_select_chk #(
  .NUM_THREADS(NUM_THREADS), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
  .thr_state(thr_state), .head_ready(head_ready), .head_nonspec(head_nonspec),
  .head_seq(head_seq), .sel_valid(sel_valid), .sel_ready(sel_ready),
  .sel_tid(sel_tid), .sel_count(sel_count), .sel_nonspec(sel_nonspec)
);

// File: tb/tb_cts_commit_select.sv
module tb_cts_commit_select;
  localparam int N = 4;
  localparam int W = 4;
  localparam int S = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   policy = 2'd0;
  logic [N-1:0] thr_active = '0;
  logic [3*N-1:0] thr_state = '0;
  logic [N*W-1:0] head_ready = '0;
  logic [N*W-1:0] head_nonspec = '0;
  logic [N*S-1:0] head_seq = '0;
  logic         sel_valid;
  logic         sel_ready = 1'b0;
  logic [1:0]   sel_tid;
  logic [2:0]   sel_count;
  logic         sel_nonspec;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cts_commit_select #(.NUM_THREADS(N), .COMMIT_W(W), .SEQ_W(S)) dut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
    .thr_state(thr_state), .head_ready(head_ready), .head_nonspec(head_nonspec),
    .head_seq(head_seq), .sel_valid(sel_valid), .sel_ready(sel_ready),
    .sel_tid(sel_tid), .sel_count(sel_count), .sel_nonspec(sel_nonspec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_thr(input int t, input logic act, input logic [2:0] st,
                         input logic [W-1:0] rdy, input logic [W-1:0] ns,
                         input logic [S-1:0] seq);
    thr_active[t]         = act;
    thr_state[3*t +: 3]   = st;
    head_ready[t*W +: W]  = rdy;
    head_nonspec[t*W +: W] = ns;
    head_seq[t*S +: S]    = seq;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sel_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one accepted handshake at the next edge
  task automatic accept_one();
    sel_ready = 1'b1;
    @(negedge clk);
    sel_ready = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int t = 0; t < N; t++) set_thr(t, 1'b0, 3'd0, 4'hF, 4'h0, 16'd0);
    #1;
    chk("R1 no active thread gives no offer", int'(sel_valid), 0);
  endtask

  task automatic t_eligibility();
    policy = 2'd0;
    set_thr(0, 1'b1, 3'd1, 4'hF, 4'h0, 16'd1);  // idle
    set_thr(1, 1'b1, 3'd2, 4'hF, 4'h0, 16'd1);  // squashing
    set_thr(2, 1'b1, 3'd3, 4'hF, 4'h0, 16'd1);  // trap pending
    set_thr(3, 1'b1, 3'd4, 4'hF, 4'h0, 16'd1);  // fetch-trap pending
    #1;
    chk("R1 non-running states give no offer", int'(sel_valid), 0);
    set_thr(3, 1'b1, 3'd0, 4'hE, 4'h0, 16'd1);  // running, slot0 not ready
    #1;
    chk("R1 slot0 not ready gives no offer", int'(sel_valid), 0);
    set_thr(3, 1'b1, 3'd0, 4'hF, 4'h0, 16'd1);
    #1;
    chk("R1 only running thread offered valid", int'(sel_valid), 1);
    chk("R1 only running thread offered tid", int'(sel_tid), 3);
    set_thr(3, 1'b0, 3'd0, 4'hF, 4'h0, 16'd1);
    #1;
    chk("R1 inactive thread not offered", int'(sel_valid), 0);
  endtask

  task automatic t_greedy();
    policy = 2'd0;
    set_thr(0, 1'b1, 3'd2, 4'hF, 4'h0, 16'd9);
    set_thr(1, 1'b1, 3'd0, 4'h7, 4'h0, 16'd9);
    set_thr(2, 1'b1, 3'd0, 4'hF, 4'h0, 16'd1);
    set_thr(3, 1'b1, 3'd0, 4'hF, 4'h0, 16'd1);
    #1;
    chk("R2 lowest eligible index", int'(sel_tid), 1);
    chk("R7 three leading ready slots", int'(sel_count), 3);
    policy = 2'd3;
    #1;
    chk("R2 spare code behaves greedy", int'(sel_tid), 1);
  endtask

  task automatic t_count();
    policy = 2'd0;
    for (int t = 1; t < N; t++) set_thr(t, 1'b0, 3'd0, 4'h0, 4'h0, 16'd0);
    set_thr(0, 1'b1, 3'd0, 4'hF, 4'h0, 16'd0);
    #1;
    chk("R7 full window", int'(sel_count), 4);
    chk("R8 no nonspec flag", int'(sel_nonspec), 0);
    set_thr(0, 1'b1, 3'd0, 4'b1011, 4'h0, 16'd0);
    #1;
    chk("R7 gap stops count", int'(sel_count), 2);
    set_thr(0, 1'b1, 3'd0, 4'hF, 4'b0100, 16'd0);
    #1;
    chk("R8 deep nonspec stops count", int'(sel_count), 2);
    chk("R8 deep nonspec not flagged", int'(sel_nonspec), 0);
    set_thr(0, 1'b1, 3'd0, 4'hF, 4'b0011, 16'd0);
    #1;
    chk("R8 head nonspec count", int'(sel_count), 1);
    chk("R8 head nonspec flag", int'(sel_nonspec), 1);
  endtask

  task automatic t_rotate();
    do_reset();
    policy = 2'd1;
    for (int t = 0; t < N; t++) set_thr(t, 1'b1, 3'd0, 4'h1, 4'h0, 16'd5);
    #1;
    chk("R3 reset order starts at 0", int'(sel_tid), 0);
    accept_one();
    chk("R4 after grant 0 offer 1", int'(sel_tid), 1);
    accept_one();
    chk("R4 after grant 1 offer 2", int'(sel_tid), 2);
    accept_one();
    chk("R4 after grant 2 offer 3", int'(sel_tid), 3);   // order 3,0,1,2
    set_thr(3, 1'b1, 3'd2, 4'h1, 4'h0, 16'd5);
    #1;
    chk("R3 squashing head of order skipped", int'(sel_tid), 0);
    @(negedge clk); #1;                                  // ready low
    chk("R5 back-pressure freezes order", int'(sel_tid), 0);
    accept_one();                                        // order 3,1,2,0
    set_thr(3, 1'b1, 3'd0, 4'h1, 4'h0, 16'd5);
    #1;
    chk("R4 skipped thread keeps its place", int'(sel_tid), 3);
    set_thr(3, 1'b0, 3'd0, 4'h1, 4'h0, 16'd5);
    #1;
    chk("R4 granted thread moved behind others", int'(sel_tid), 1);
  endtask

  task automatic t_oldest();
    // order currently 3,1,2,0
    policy = 2'd2;
    set_thr(0, 1'b1, 3'd0, 4'h1, 4'h0, 16'd50);
    set_thr(1, 1'b1, 3'd0, 4'h1, 4'h0, 16'd20);
    set_thr(2, 1'b1, 3'd0, 4'h1, 4'h0, 16'd20);
    set_thr(3, 1'b1, 3'd3, 4'h1, 4'h0, 16'd10);
    #1;
    chk("R6 tie goes to lower index", int'(sel_tid), 1);
    set_thr(3, 1'b1, 3'd0, 4'h1, 4'h0, 16'd10);
    #1;
    chk("R6 smallest sequence wins", int'(sel_tid), 3);
    accept_one();
    accept_one();
    policy = 2'd1;
    #1;
    chk("R5 oldest-mode grants leave order", int'(sel_tid), 3);
    policy = 2'd0;
    #1;
    chk("R2 greedy ignores sequence", int'(sel_tid), 0);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_eligibility();
    t_greedy();
    t_count();
    t_rotate();
    t_oldest();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule